// File: doc/BRIEF.md
# Pell Root Pair Modular Generator

This block takes an 8-bit character code P and a 16-bit primary key K and produces two key-reduced squares that come from a solution of the Pell equation b² = P·a² + 1. It first rejects a code P that is a perfect square. Otherwise it tries a = 1, 2, 3, … in turn until P·a² + 1 is a perfect square. The square test is an incremental integer square root, which moves the candidate b up by one each cycle.

From this smallest pair it can apply the doubling composition (a, b) → (2ab, b² + P·a²) a selectable number of times. It then returns qa = a² mod K and qb = b² mod K. The composition is carried out on residues modulo K, so every datapath width is fixed and no value grows without bound. Each reduction is a shift-and-subtract loop that takes one dividend bit per cycle.

A single start pulse launches a job, busy covers the run, and a one-cycle done pulse ends it. With done, exactly one of three flags is raised: result valid, bad input, or search timeout.

Top module: `pell_pair_gen`

## Requirements
- R1: A start while idle with a nonzero key raises busy in the next cycle. The job ends with done high for exactly one cycle, and busy is already low in that cycle.
- R2: A start while busy is ignored, and the result reflects only the inputs sampled at the accepted start. A start in the done cycle is accepted, and busy is high in the next cycle.
- R3: If P is a perfect square (0, 1, 4, 9, …), done comes with bad_input = 1, valid = 0 and timeout = 0.
- R4: A key K of 0 gives done with bad_input = 1 in the cycle after start, and busy stays low throughout.
- R5: The fundamental pair is the one with the smallest a ≥ 1 for which b² = P·a² + 1, with b > 0.
- R6: If no a up to MAX_A (default 1023) solves the equation, done comes with timeout = 1, valid = 0 and bad_input = 0.
- R7: The composition (a, b) → (2ab, b² + P·a²) is applied exactly n_comp times (0 to 15) to the fundamental pair before the outputs are formed.
- R8: With valid = 1, qa = a² mod K and qb = b² mod K for the final pair, and both are less than K.
- R9: qa, qb and the three flags hold their values after done until the next accepted start, whatever the inputs do in the meantime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Job request, accepted only while idle |
| p_in | input | 8 | Character code P |
| k1_in | input | 16 | Primary key K |
| n_comp | input | 4 | Number of composition steps |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| valid | output | 1 | qa and qb are valid |
| bad_input | output | 1 | P is a perfect square or K is zero |
| timeout | output | 1 | No solution found up to MAX_A |
| qa | output | 16 | a² mod K |
| qb | output | 16 | b² mod K |

## Verification
The case that needs care is a start request that meets the end of a job. A start raised while the last reduction is finishing must be dropped. A start raised in the done cycle itself must begin a fresh job at once.

The bench provokes the first case by pulsing new start requests with different inputs at several points during a long run. It then requires the original result, and it requires busy to stay low after done.

It provokes the second case by raising start with new inputs in the very cycle done is seen. It then requires busy one cycle later and the second job's own result.

// File: rtl/pell_pkg.sv
package pell_pkg;

    typedef enum logic [1:0] {
        SR_IDLE,
        SR_CHK,
        SR_RUN
    } srch_st_e;

    typedef enum logic [2:0] {
        TP_IDLE,
        TP_SEARCH,
        TP_RED_A,
        TP_RED_B,
        TP_CMP_A,
        TP_CMP_B,
        TP_SQ_A,
        TP_SQ_B
    } top_st_e;

    function automatic int pell_aw(input int max_a);
        return $clog2(max_a + 1);
    endfunction

    function automatic int pell_tw(input int pw, input int aw);
        return pw + 2 * aw + 1;
    endfunction

    function automatic int pell_sw(input int tw);
        return tw / 2 + 2;
    endfunction

endpackage

// File: rtl/pell_search.sv
module pell_search
    import pell_pkg::*;
#(
    parameter int PW    = 8,
    parameter int MAX_A = 1023,
    parameter int AW    = pell_aw(MAX_A),
    parameter int SW    = pell_sw(pell_tw(PW, AW))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] p,
    output logic          done,
    output logic          found,
    output logic          square,
    output logic          tout,
    output logic [AW-1:0] a_o,
    output logic [SW-1:0] b_o
);

    localparam int TW  = pell_tw(PW, AW);
    localparam int S2W = 2 * SW;
    localparam int RW  = PW / 2 + 2;
    localparam int R2W = 2 * RW;

    typedef struct packed {
        srch_st_e       st;
        logic [PW-1:0]  p;
        logic [RW-1:0]  r;
        logic [R2W-1:0] r2;
        logic [AW-1:0]  a;
        logic [TW-1:0]  t;
        logic [SW-1:0]  s;
        logic [S2W-1:0] s2;
        logic           done;
        logic           found;
        logic           square;
        logic           tout;
    } srch_t;

    srch_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            SR_IDLE: begin
                if (start) begin
                    d.st     = SR_CHK;
                    d.p      = p;
                    d.r      = '0;
                    d.r2     = '0;
                    d.found  = 1'b0;
                    d.square = 1'b0;
                    d.tout   = 1'b0;
                end
            end
            SR_CHK: begin
                if (q.r2 == R2W'(q.p)) begin
                    d.square = 1'b1;
                    d.done   = 1'b1;
                    d.st     = SR_IDLE;
                end else if (q.r2 > R2W'(q.p)) begin
                    d.st = SR_RUN;
                    d.a  = AW'(1);
                    d.t  = TW'(q.p) + TW'(1);
                    d.s  = SW'(1);
                    d.s2 = S2W'(1);
                end else begin
                    d.r  = q.r + RW'(1);
                    d.r2 = q.r2 + R2W'({q.r, 1'b1});
                end
            end
            SR_RUN: begin
                if (q.s2 < S2W'(q.t)) begin
                    d.s  = q.s + SW'(1);
                    d.s2 = q.s2 + S2W'({q.s, 1'b1});
                end else if (q.s2 == S2W'(q.t)) begin
                    d.found = 1'b1;
                    d.done  = 1'b1;
                    d.st    = SR_IDLE;
                end else if (q.a == AW'(MAX_A)) begin
                    d.tout = 1'b1;
                    d.done = 1'b1;
                    d.st   = SR_IDLE;
                end else begin
                    d.a = q.a + AW'(1);
                    d.t = q.t + TW'(q.p) * TW'({q.a, 1'b1});
                end
            end
            default: d.st = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done   = q.done;
    assign found  = q.found;
    assign square = q.square;
    assign tout   = q.tout;
    assign a_o    = q.a;
    assign b_o    = q.s;

    // R5: a reported pair solves the equation
    assert_root_solves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.found) |->
            (S2W'(q.s) * S2W'(q.s) == S2W'(q.p) * S2W'(q.a) * S2W'(q.a) + S2W'(1)));

    // R6: a timeout only happens once a has reached its bound
    assert_timeout_at_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.tout) |-> (q.a == AW'(MAX_A)));

endmodule

// File: rtl/pell_modred.sv
module pell_modred #(
    parameter int XW = 41,
    parameter int KW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [XW-1:0] x,
    input  logic [KW-1:0] k,
    output logic          done,
    output logic [KW-1:0] rem
);

    localparam int CNW = $clog2(XW + 1);

    typedef struct packed {
        logic           busy;
        logic [CNW-1:0] cnt;
        logic [XW-1:0]  x;
        logic [KW-1:0]  rem;
        logic           done;
    } red_t;

    red_t q, d;
    logic [KW:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.x[XW-1]};
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.cnt  = CNW'(XW);
                d.x    = x;
                d.rem  = '0;
            end
        end else begin
            if (trial >= {1'b0, k}) begin
                d.rem = KW'(trial - {1'b0, k});
            end else begin
                d.rem = KW'(trial);
            end
            d.x   = {q.x[XW-2:0], 1'b0};
            d.cnt = q.cnt - CNW'(1);
            if (q.cnt == CNW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign rem  = q.rem;

    // R8: the partial remainder stays below the key
    assert_rem_below_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy || q.done) |-> (q.rem < k));

endmodule

// File: rtl/pell_pair_gen.sv
module pell_pair_gen
    import pell_pkg::*;
#(
    parameter int PW    = 8,
    parameter int KW    = 16,
    parameter int CW    = 4,
    parameter int MAX_A = 1023
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] p_in,
    input  logic [KW-1:0] k1_in,
    input  logic [CW-1:0] n_comp,
    output logic          busy,
    output logic          done,
    output logic          valid,
    output logic          bad_input,
    output logic          timeout,
    output logic [KW-1:0] qa,
    output logic [KW-1:0] qb
);

    localparam int AW  = pell_aw(MAX_A);
    localparam int SW  = pell_sw(pell_tw(PW, AW));
    localparam int XW0 = 2 * KW + PW + 1;
    localparam int XW1 = (XW0 > SW) ? XW0 : SW;
    localparam int XW  = (XW1 > AW) ? XW1 : AW;

    typedef struct packed {
        top_st_e       st;
        logic [PW-1:0] p;
        logic [KW-1:0] k;
        logic [CW-1:0] n;
        logic [KW-1:0] ra;
        logic [KW-1:0] rb;
        logic [KW-1:0] tmp;
        logic [XW-1:0] opnd;
        logic          red_go;
        logic          srch_go;
        logic [KW-1:0] qa;
        logic [KW-1:0] qb;
        logic          valid;
        logic          bad;
        logic          tout;
        logic          done;
    } top_t;

    top_t q, d;

    logic          s_done, s_found, s_square, s_tout;
    logic [AW-1:0] s_a;
    logic [SW-1:0] s_b;
    logic          r_done;
    logic [KW-1:0] r_rem;
    logic [XW-1:0] ra_x, rb_x, p_x, tmp_x, rr_x;

    pell_search #(
        .PW   (PW),
        .MAX_A(MAX_A),
        .AW   (AW),
        .SW   (SW)
    ) u_search (
        .clk   (clk),
        .rst_n (rst_n),
        .start (q.srch_go),
        .p     (q.p),
        .done  (s_done),
        .found (s_found),
        .square(s_square),
        .tout  (s_tout),
        .a_o   (s_a),
        .b_o   (s_b)
    );

    pell_modred #(
        .XW(XW),
        .KW(KW)
    ) u_modred (
        .clk  (clk),
        .rst_n(rst_n),
        .start(q.red_go),
        .x    (q.opnd),
        .k    (q.k),
        .done (r_done),
        .rem  (r_rem)
    );

    assign ra_x  = XW'(q.ra);
    assign rb_x  = XW'(q.rb);
    assign p_x   = XW'(q.p);
    assign tmp_x = XW'(q.tmp);
    assign rr_x  = XW'(r_rem);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.red_go  = 1'b0;
        d.srch_go = 1'b0;
        case (q.st)
            TP_IDLE: begin
                if (start) begin
                    d.p     = p_in;
                    d.k     = k1_in;
                    d.n     = n_comp;
                    d.valid = 1'b0;
                    d.bad   = 1'b0;
                    d.tout  = 1'b0;
                    if (k1_in == '0) begin
                        d.bad  = 1'b1;
                        d.done = 1'b1;
                    end else begin
                        d.st      = TP_SEARCH;
                        d.srch_go = 1'b1;
                    end
                end
            end
            TP_SEARCH: begin
                if (s_done) begin
                    if (s_found) begin
                        d.opnd   = XW'(s_a);
                        d.red_go = 1'b1;
                        d.st     = TP_RED_A;
                    end else begin
                        d.bad  = s_square;
                        d.tout = s_tout;
                        d.done = 1'b1;
                        d.st   = TP_IDLE;
                    end
                end
            end
            TP_RED_A: begin
                if (r_done) begin
                    d.ra     = r_rem;
                    d.opnd   = XW'(s_b);
                    d.red_go = 1'b1;
                    d.st     = TP_RED_B;
                end
            end
            TP_RED_B: begin
                if (r_done) begin
                    d.rb     = r_rem;
                    d.red_go = 1'b1;
                    if (q.n == '0) begin
                        d.opnd = ra_x * ra_x;
                        d.st   = TP_SQ_A;
                    end else begin
                        d.opnd = (ra_x * rr_x) << 1;
                        d.st   = TP_CMP_A;
                    end
                end
            end
            TP_CMP_A: begin
                if (r_done) begin
                    d.tmp    = r_rem;
                    d.opnd   = rb_x * rb_x + p_x * ra_x * ra_x;
                    d.red_go = 1'b1;
                    d.st     = TP_CMP_B;
                end
            end
            TP_CMP_B: begin
                if (r_done) begin
                    d.ra     = q.tmp;
                    d.rb     = r_rem;
                    d.n      = q.n - CW'(1);
                    d.red_go = 1'b1;
                    if (q.n == CW'(1)) begin
                        d.opnd = tmp_x * tmp_x;
                        d.st   = TP_SQ_A;
                    end else begin
                        d.opnd = (tmp_x * rr_x) << 1;
                        d.st   = TP_CMP_A;
                    end
                end
            end
            TP_SQ_A: begin
                if (r_done) begin
                    d.qa     = r_rem;
                    d.opnd   = rb_x * rb_x;
                    d.red_go = 1'b1;
                    d.st     = TP_SQ_B;
                end
            end
            TP_SQ_B: begin
                if (r_done) begin
                    d.qb    = r_rem;
                    d.valid = 1'b1;
                    d.done  = 1'b1;
                    d.st    = TP_IDLE;
                end
            end
            default: d.st = TP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != TP_IDLE);
    assign done      = q.done;
    assign valid     = q.valid;
    assign bad_input = q.bad;
    assign timeout   = q.tout;
    assign qa        = q.qa;
    assign qb        = q.qb;

    // R1: done lasts one cycle and never overlaps busy
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: a start during busy leaves the captured inputs unchanged
    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(q.p) && $stable(q.k)));

    // R6: each job ends with exactly one outcome flag
    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({valid, bad_input, timeout}) == 1));

    // R8: reduced results lie below the key
    assert_result_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> ((qa < q.k) && (qb < q.k)));

    // R9: results are held while idle without an accepted start
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !done) |=> ($stable(qa) && $stable(qb) && $stable(valid)));

endmodule

// File: tb/sim_pell_pair_gen.sv
`timescale 1ns/1ps
module sim_pell_pair_gen;

    localparam int MAXA = 1023;
    localparam int WAIT_LIMIT = 40000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  p_in = '0;
    logic [15:0] k1_in = '0;
    logic [3:0]  n_comp = '0;
    logic        busy, done, valid, bad_input, timeout;
    logic [15:0] qa, qb;

    int n_checks = 0;
    int n_fail = 0;

    pell_pair_gen #(
        .PW(8), .KW(16), .CW(4), .MAX_A(MAXA)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .p_in(p_in), .k1_in(k1_in),
        .n_comp(n_comp), .busy(busy), .done(done), .valid(valid),
        .bad_input(bad_input), .timeout(timeout), .qa(qa), .qb(qb)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected outcome from the requirements: 0 valid, 1 bad, 2 timeout
    task automatic model(input longint p, input longint k, input int n,
                         output int kind, output longint eqa, output longint eqb);
        longint a, b, na, nb, t;
        bit sq;
        kind = 2; eqa = 0; eqb = 0;
        if (k == 0) begin kind = 1; return; end
        sq = 0;
        for (longint r = 0; r <= 16; r++) if (r * r == p) sq = 1;
        if (sq) begin kind = 1; return; end
        a = 0; b = 0;
        for (longint x = 1; x <= MAXA; x++) begin
            t = p * x * x + 1;
            b = longint'($sqrt(real'(t)));
            while (b * b > t) b--;
            while ((b + 1) * (b + 1) <= t) b++;
            if (b * b == t) begin a = x; break; end
        end
        if (a == 0) return;
        kind = 0;
        a = a % k; b = b % k;
        for (int i = 0; i < n; i++) begin
            na = (2 * a * b) % k;
            nb = (b * b + p * a * a) % k;
            a = na; b = nb;
        end
        eqa = (a * a) % k;
        eqb = (b * b) % k;
    endtask

    task automatic wait_done(input string req);
        int c = 0;
        while (!done && c < WAIT_LIMIT) begin
            @(negedge clk);
            c++;
        end
        check(c < WAIT_LIMIT, req, c, WAIT_LIMIT);
    endtask

    task automatic judge(input int kind, input longint eqa, input longint eqb, input string req);
        check(valid == (kind == 0), {req, " valid"}, valid, kind == 0);
        check(bad_input == (kind == 1), {req, " bad_input"}, bad_input, kind == 1);
        check(timeout == (kind == 2), {req, " timeout"}, timeout, kind == 2);
        if (kind == 0) begin
            check(qa == eqa, {req, " qa"}, qa, eqa);
            check(qb == eqb, {req, " qb"}, qb, eqb);
        end
    endtask

    task automatic run_job(input logic [7:0] p, input logic [15:0] k, input logic [3:0] n,
                           input string req);
        int kind; longint eqa, eqb;
        model(p, k, n, kind, eqa, eqb);
        @(negedge clk);
        p_in = p; k1_in = k; n_comp = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (k == 0) begin
            check(done == 1'b1 && busy == 1'b0, "R4 done next cycle, no busy", done, 1);
        end else begin
            check(busy == 1'b1 && done == 1'b0, "R1 busy after start", busy, 1);
        end
        wait_done(req);
        check(busy == 1'b0, "R1 busy low in done cycle", busy, 0);
        judge(kind, eqa, eqb, req);
        @(negedge clk);
        check(done == 1'b0, "R1 done single cycle", done, 0);
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0, "R1 reset idle", {busy, done}, 0);
        check(valid == 0 && bad_input == 0 && timeout == 0, "R9 reset flags",
              {valid, bad_input, timeout}, 0);
        check(qa == 0 && qb == 0, "R9 reset results", qa, 0);
    endtask

    task automatic t_solve();
        run_job(8'd2, 16'd35491, 4'd0, "R5 P=2 fundamental");
        run_job(8'd7, 16'd35491, 4'd0, "R5 P=7 fundamental");
        run_job(8'd13, 16'd35491, 4'd0, "R5 P=13 fundamental");
        run_job(8'd255, 16'd35491, 4'd0, "R5 P=255 max code");
        run_job(8'd7, 16'd35491, 4'd3, "R7 P=7 three steps");
        run_job(8'd13, 16'd35491, 4'd2, "R7 P=13 two steps");
        run_job(8'd3, 16'd35491, 4'd15, "R7 P=3 fifteen steps");
        run_job(8'd13, 16'd7, 4'd1, "R8 small key");
        run_job(8'd5, 16'd65535, 4'd4, "R8 max key");
    endtask

    task automatic t_square();
        run_job(8'd0, 16'd35491, 4'd0, "R3 P=0");
        run_job(8'd1, 16'd35491, 4'd2, "R3 P=1");
        run_job(8'd4, 16'd35491, 4'd0, "R3 P=4");
        run_job(8'd225, 16'd35491, 4'd0, "R3 P=225");
    endtask

    task automatic t_zero_key();
        run_job(8'd2, 16'd0, 4'd0, "R4 zero key");
    endtask

    task automatic t_timeout();
        run_job(8'd61, 16'd35491, 4'd0, "R6 P=61 beyond bound");
    endtask

    task automatic t_ignore_busy();
        int kind; longint eqa, eqb;
        model(13, 35491, 2, kind, eqa, eqb);
        @(negedge clk);
        p_in = 8'd13; k1_in = 16'd35491; n_comp = 4'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            repeat (97) @(negedge clk);
            p_in = 8'd7; k1_in = 16'd7; n_comp = 4'd1;
            start = busy;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done("R2 ignore wait");
        judge(kind, eqa, eqb, "R2 start ignored while busy");
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R2 no queued job", busy, 0);
    endtask

    task automatic t_back_to_back();
        int kind; longint eqa, eqb;
        model(7, 35491, 1, kind, eqa, eqb);
        run_job(8'd2, 16'd35491, 4'd0, "R2 first job");
        // rerun, then start again in the done cycle
        @(negedge clk);
        p_in = 8'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R2 wait first");
        p_in = 8'd7; k1_in = 16'd35491; n_comp = 4'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 start in done cycle accepted", busy, 1);
        wait_done("R2 wait second");
        judge(kind, eqa, eqb, "R2 second job result");
    endtask

    task automatic t_hold();
        logic [15:0] hqa, hqb;
        run_job(8'd11, 16'd35491, 4'd1, "R9 job");
        hqa = qa; hqb = qb;
        p_in = 8'd61; k1_in = 16'd3; n_comp = 4'd9;
        repeat (8) @(negedge clk);
        check(qa == hqa && qb == hqb, "R9 results held", qa, hqa);
        check(valid == 1'b1 && busy == 1'b0, "R9 valid held", valid, 1);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_solve();
        t_square();
        t_zero_key();
        t_timeout();
        t_ignore_busy();
        t_back_to_back();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule